// File: doc/BRIEF.md
# Single-Wire Return-to-One Register Responder

This block is the device end of a single-wire, open-drain, return-to-one serial link. It samples the shared line and resynchronises whenever the host holds the line low for a long break. It then takes in a command byte, sent least-significant bit first, whose bits are told apart by the width of each low pulse. Write commands put the following byte into a 128-entry byte register file. Read commands make the block send the addressed byte back on its own after a fixed turnaround, with device-side bit timing, by pulling the line low through `line_pull`.

Internal logic can also update any register through a local write port. A pulse whose width fits neither a bit nor a break counts as a framing error, and the block then ignores the line until the next break. All durations are counted in clock cycles and set by parameters. Defaults: break 100, a low pulse shorter than 20 reads as 1, a 0 lasts at most 60, turnaround 30, device low 10, device data window 40, device bit cycle 60.

Top module: `rtz_target`

## Requirements
- R1: After reset `line_pull` is 0, and every pulse is ignored until the first break is seen.
- R2: A low lasting at least `T_BREAK` samples, arriving in any state except while the block is transmitting, clears the bit and byte progress, including a partly received byte. The block waits for the line to go high and then expects a command byte.
- R3: A low pulse of width w (in samples) decodes as 1 when w < `T_ONE_LIM` and as 0 when `T_ONE_LIM` <= w <= `T_ZERO_MAX`. Bits arrive LSB first. Command bit 7 = 1 means write and 0 means read. Bits 6:0 are the register address.
- R4: After a write command, the next eight bits are stored into the addressed register.
- R5: For a read, `line_pull` first rises on the (`T_TURN`+3)-th rising clock edge after the line goes high at the end of the command's last bit.
- R6: Each response bit holds `line_pull` high for `T_DLOW` cycles, then at the inverse of the data bit until cycle `T_DDATA`, then low until cycle `T_DCYC`. Bits go out LSB first.
- R7: A low pulse wider than `T_ZERO_MAX` but shorter than `T_BREAK` is a framing error. The block then ignores all traffic until the next break.
- R8: A local write with `loc_we` updates the register on that clock. If the host stores to the same address on the same clock, the local value is kept.
- R9: The byte sent for a read is captured when the command byte completes. Later updates to that register during the turnaround or the transmission do not change it.
- R10: Once a write's data byte or a read response has finished, the next command is accepted with no new break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Sampled level of the shared line (1 = released) |
| line_pull | output | 1 | 1 pulls the shared line low |
| loc_we | input | 1 | Local register write strobe |
| loc_addr | input | 7 | Local write address |
| loc_wdata | input | 8 | Local write data |

## Verification
The bench exercises pulse widths right at the 1/0 decision limit. A design with an off-by-one comparison there would send back a different register than the one addressed. It sends a command without a break first, then an over-long pulse in the middle of a byte, then a break halfway through a byte. A block that did not resynchronise would answer commands it should ignore, or read bits out of phase. It places a local write on the exact clock a host write lands, and another local write during a read's turnaround. A design that got the priority or the capture moment wrong would return the host's value or the newer value in the response.

// File: rtl/rtz_target.sv
`timescale 1ns/1ps
module rtz_target #(
  parameter int DATA_W     = 8,
  parameter int T_BREAK    = 100,
  parameter int T_ONE_LIM  = 20,
  parameter int T_ZERO_MAX = 60,
  parameter int T_TURN     = 30,
  parameter int T_DLOW     = 10,
  parameter int T_DDATA    = 40,
  parameter int T_DCYC     = 60
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_in,
  output logic                line_pull,
  input  logic                loc_we,
  input  logic [DATA_W-2:0]   loc_addr,
  input  logic [DATA_W-1:0]   loc_wdata
);
  localparam int ADDR_W = DATA_W - 1;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int BW     = $clog2(DATA_W);
  localparam int LW     = $clog2(T_BREAK + 1);
  localparam int TMAX   = (T_TURN > T_DCYC) ? T_TURN : T_DCYC;
  localparam int TW     = $clog2(TMAX + 1);

  typedef enum logic [2:0] {WAIT_BRK = 3'd0, WAIT_HIGH = 3'd1, RX = 3'd2,
                            TURN = 3'd3, TX = 3'd4} st_t;

  st_t                st;
  logic               s1, s2, prev;
  logic [LW-1:0]      lowcnt;
  logic               is_data;
  logic [DATA_W-1:0]  sh;
  logic [BW-1:0]      nbit;
  logic [ADDR_W-1:0]  addr;
  logic [DATA_W-1:0]  rbuf;
  logic [TW-1:0]      tmr;
  logic [DATA_W-1:0]  mem [DEPTH];

  wire               rise    = s2 & ~prev;
  wire               brk     = ~s2 && (lowcnt == LW'(T_BREAK - 1)) && (st != TX);
  wire               bit_ok  = lowcnt <= LW'(T_ZERO_MAX);
  wire               rx_bit  = lowcnt < LW'(T_ONE_LIM);
  wire [DATA_W-1:0]  sh_nx   = {rx_bit, sh[DATA_W-1:1]};
  wire               last    = nbit == BW'(DATA_W - 1);
  wire               host_wr = (st == RX) && rise && bit_ok && last && is_data && !brk;

  assign line_pull = (st == TX) &&
                     ((tmr < TW'(T_DLOW)) || ((tmr < TW'(T_DDATA)) && !rbuf[nbit]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; prev <= 1'b1; lowcnt <= '0;
    end else begin
      s1 <= line_in; s2 <= s1; prev <= s2;
      if (s2) lowcnt <= '0;
      else if (lowcnt != LW'(T_BREAK - 1)) lowcnt <= lowcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= WAIT_BRK; is_data <= 1'b0; sh <= '0; nbit <= '0;
      addr <= '0; rbuf <= '0; tmr <= '0;
    end else if (brk) begin
      st <= WAIT_HIGH; nbit <= '0; is_data <= 1'b0;
    end else begin
      case (st)
        WAIT_HIGH: if (s2) begin st <= RX; nbit <= '0; is_data <= 1'b0; end
        RX: if (rise) begin
          if (!bit_ok) st <= WAIT_BRK;
          else begin
            sh   <= sh_nx;
            nbit <= nbit + 1'b1;
            if (last) begin
              nbit <= '0;
              if (is_data) is_data <= 1'b0;
              else if (sh_nx[DATA_W-1]) begin
                is_data <= 1'b1;
                addr    <= sh_nx[ADDR_W-1:0];
              end else begin
                rbuf <= mem[sh_nx[ADDR_W-1:0]];
                st   <= TURN;
                tmr  <= '0;
              end
            end
          end
        end
        TURN: if (tmr == TW'(T_TURN - 1)) begin
          st <= TX; tmr <= '0; nbit <= '0;
        end else tmr <= tmr + 1'b1;
        TX: if (tmr == TW'(T_DCYC - 1)) begin
          tmr  <= '0;
          nbit <= nbit + 1'b1;
          if (last) st <= RX;
        end else tmr <= tmr + 1'b1;
        default: st <= WAIT_BRK;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (host_wr) mem[addr] <= sh_nx;
      if (loc_we)  mem[loc_addr] <= loc_wdata;
    end
  end
endmodule

// File: rtl/rtz_target_chk.sv
`timescale 1ns/1ps
module rtz_target_chk #(
  parameter int DATA_W  = 8,
  parameter int T_BREAK = 100,
  parameter int T_DDATA = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_in,
  input logic              line_pull,
  input logic              loc_we,
  input logic [DATA_W-2:0] loc_addr,
  input logic [DATA_W-1:0] loc_wdata,
  input logic [2:0]        st,
  input logic [DATA_W-1:0] rbuf,
  input logic [DATA_W-1:0] mem_q [1 << (DATA_W-1)]
);
  localparam logic [2:0] C_WAIT_BRK = 3'd0, C_WAIT_HIGH = 3'd1, C_TURN = 3'd3, C_TX = 3'd4;

  int lo_run, pr_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run <= 0; pr_run <= 0;
    end else begin
      lo_run <= line_in ? 0 : ((lo_run < T_BREAK + 10) ? lo_run + 1 : lo_run);
      pr_run <= line_pull ? pr_run + 1 : 0;
      a_r2_break_resync: assert (!(lo_run >= T_BREAK + 3 && st != C_TX) || st == C_WAIT_HIGH)
        else $error("R2: long low did not resynchronise");
      a_r6_pull_bounded: assert (pr_run <= T_DDATA)
        else $error("R6: pull held beyond data window");
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_WAIT_BRK) |-> !line_pull) else $error("R1: pull while waiting for break");

  a_r5_tx_after_turn: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == C_TX) |-> $past(st) == C_TURN) else $error("R5: response without turnaround");

  a_r9_snapshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_TX) |-> $stable(rbuf)) else $error("R9: response byte changed");

  a_r8_local_wins: assert property (@(posedge clk) disable iff (!rst_n)
    loc_we |=> mem_q[$past(loc_addr)] == $past(loc_wdata)) else $error("R8: local write lost");
endmodule

bind rtz_target rtz_target_chk #(.DATA_W(DATA_W), .T_BREAK(T_BREAK), .T_DDATA(T_DDATA)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_in(line_in), .line_pull(line_pull),
  .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
  .st(st), .rbuf(rbuf), .mem_q(mem));

// File: tb/tb_rtz_target.sv
`timescale 1ns/1ps
module tb_rtz_target;
  localparam int BRK = 100, ONE = 20, ZMAX = 60, TURN = 30, DLOW = 10, DDATA = 40, DCYC = 60;
  localparam int HW1 = 8, HW0 = 35, GAP = 20;

  logic       clk = 1'b0, rst_n = 1'b0, host_low = 1'b0, loc_we = 1'b0;
  logic [6:0] loc_addr = '0;
  logic [7:0] loc_wdata = '0;
  wire        line_pull;
  wire        line = ~(host_low | line_pull);

  int    checks = 0, fails = 0;
  bit    exp_q[$];
  string cur_req = "R1";

  always #4 clk = ~clk;

  rtz_target #(.T_BREAK(BRK), .T_ONE_LIM(ONE), .T_ZERO_MAX(ZMAX), .T_TURN(TURN),
               .T_DLOW(DLOW), .T_DDATA(DDATA), .T_DCYC(DCYC)) dut (
    .clk(clk), .rst_n(rst_n), .line_in(line), .line_pull(line_pull),
    .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata));

  task automatic tick();
    bit e;
    @(negedge clk);
    if (exp_q.size() > 0) e = exp_q.pop_front(); else e = 1'b0;
    checks++;
    if (line_pull !== e) begin
      fails++;
      $display("FAIL %s: line_pull actual %0b expected %0b at %0t", cur_req, line_pull, e, $time);
    end
  endtask

  task automatic push_rsp(input logic [7:0] v);
    repeat (2 + TURN) exp_q.push_back(1'b0);
    for (int b = 0; b < 8; b++) begin
      repeat (DLOW) exp_q.push_back(1'b1);
      repeat (DDATA - DLOW) exp_q.push_back(~v[b]);
      repeat (DCYC - DDATA) exp_q.push_back(1'b0);
    end
  endtask

  task automatic host_pulse(input int w, input bit do_rsp, input logic [7:0] rv,
                            input bit do_coll, input logic [6:0] ca, input logic [7:0] cd);
    host_low = 1'b1;
    repeat (w) tick();
    host_low = 1'b0;
    if (do_rsp) push_rsp(rv);
    for (int i = 0; i < GAP; i++) begin
      if (do_coll && i == 2) begin loc_we = 1'b1; loc_addr = ca; loc_wdata = cd; end
      if (do_coll && i == 3) loc_we = 1'b0;
      tick();
    end
  endtask

  task automatic host_byte(input logic [7:0] v, input bit edge_w, input bit do_rsp,
                           input logic [7:0] rv, input bit do_coll,
                           input logic [6:0] ca, input logic [7:0] cd);
    for (int i = 0; i < 8; i++)
      host_pulse(v[i] ? (edge_w ? ONE - 1 : HW1) : (edge_w ? ZMAX : HW0),
                 do_rsp && i == 7, rv, do_coll && i == 7, ca, cd);
  endtask

  task automatic send_break();
    host_low = 1'b1;
    repeat (BRK + 20) tick();
    host_low = 1'b0;
    repeat (GAP) tick();
  endtask

  task automatic rd(input logic [6:0] a, input logic [7:0] v, input bit expect_rsp, input bit edge_w);
    host_byte({1'b0, a}, edge_w, expect_rsp, v, 1'b0, '0, '0);
    repeat (TURN + 8 * DCYC + 10 - GAP) tick();
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d, input bit coll,
                    input logic [6:0] ca, input logic [7:0] cd);
    host_byte({1'b1, a}, 1'b0, 1'b0, '0, 1'b0, '0, '0);
    host_byte(d, 1'b0, 1'b0, '0, coll, ca, cd);
  endtask

  task automatic lwr(input logic [6:0] a, input logic [7:0] d);
    loc_we = 1'b1; loc_addr = a; loc_wdata = d;
    tick();
    loc_we = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: cycles actual 200000 expected fewer");
    summary();
    $finish;
  end

  initial begin
    cur_req = "R1";
    repeat (5) tick();
    rst_n = 1'b1;
    repeat (5) tick();
    lwr(7'h05, 8'hA5);
    rd(7'h05, 8'h00, 1'b0, 1'b0);

    send_break();
    cur_req = "R5/R6/R8";
    rd(7'h05, 8'hA5, 1'b1, 1'b0);

    cur_req = "R4/R10";
    wr(7'h12, 8'h3C, 1'b0, '0, '0);
    rd(7'h12, 8'h3C, 1'b1, 1'b0);
    wr(7'h7F, 8'h81, 1'b0, '0, '0);
    rd(7'h7F, 8'h81, 1'b1, 1'b0);

    cur_req = "R3";
    lwr(7'h2A, 8'h6E);
    lwr(7'h55, 8'h11);
    rd(7'h2A, 8'h6E, 1'b1, 1'b1);
    rd(7'h55, 8'h11, 1'b1, 1'b1);

    cur_req = "R7";
    send_break();
    for (int i = 0; i < 3; i++) host_pulse(HW1, 1'b0, '0, 1'b0, '0, '0);
    host_pulse(75, 1'b0, '0, 1'b0, '0, '0);
    rd(7'h05, 8'hA5, 1'b0, 1'b0);
    send_break();
    rd(7'h05, 8'hA5, 1'b1, 1'b0);

    cur_req = "R2";
    for (int i = 0; i < 4; i++) host_pulse(HW0, 1'b0, '0, 1'b0, '0, '0);
    send_break();
    rd(7'h12, 8'h3C, 1'b1, 1'b0);

    cur_req = "R8";
    wr(7'h20, 8'h11, 1'b1, 7'h20, 8'h99);
    rd(7'h20, 8'h99, 1'b1, 1'b0);
    wr(7'h21, 8'h44, 1'b1, 7'h22, 8'h77);
    rd(7'h21, 8'h44, 1'b1, 1'b0);
    rd(7'h22, 8'h77, 1'b1, 1'b0);

    cur_req = "R9";
    lwr(7'h30, 8'h0F);
    host_byte({1'b0, 7'h30}, 1'b0, 1'b1, 8'h0F, 1'b0, '0, '0);
    tick();
    lwr(7'h30, 8'hF0);
    repeat (TURN + 8 * DCYC + 10 - GAP - 2) tick();
    rd(7'h30, 8'hF0, 1'b1, 1'b0);

    repeat (20) tick();
    summary();
    $finish;
  end
endmodule